// File: doc/BRIEF.md
# Peripheral Bus Requester with Address Decode

This block is the only initiator on a low-bandwidth peripheral bus of the APB3 kind. On the system side it takes one command at a time through a valid/ready handshake. A command carries an address, a write flag and write data. The block turns each command into a two-phase bus transfer. First it selects one peripheral for a single cycle. It then raises the enable strobe and holds it until the addressed peripheral signals ready. After that it returns one response pulse carrying the read data and an error flag.

The peripheral select lines come from a combinational decode of the command address. By default there are four peripheral windows of 4 KB each. Address bits [13:12] pick the window, and every address bit above bit 13 must be zero. An address outside the map never reaches the bus and is answered at once with an error. A command presented in the cycle that completes a transfer starts its own select phase on the next edge, so no idle cycle falls between the two transfers.

Top module: `apbm_requester`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs that follow that edge have all `psel` bits low, `penable` low and `rsp_valid` low. The first cycle after reset is idle, so `cmd_ready` is high.
- R2: A command accepted with an in-map address drives `psel` bit `cmd_addr[13:12]` on the next cycle with `penable` low. That select phase lasts exactly one cycle, and `penable` is high in the cycle after it.
- R3: `psel` never has more than one bit set, and `penable` is high only while one `psel` bit is set.
- R4: `paddr`, `pwrite`, `pwdata` and `psel` keep their values from the select cycle through the last enable cycle of the same transfer.
- R5: While `pready` is low during an enable cycle, `penable` and the select remain high on the next cycle, which adds a wait state.
- R6: In the cycle after an enable cycle with `pready` high, `rsp_valid` is high for exactly one cycle. `rsp_rdata` then holds the `prdata` sampled in that completing cycle for a read, and 0 for a write.
- R7: `pslverr` is sampled only in the completing enable cycle and is returned as `rsp_err`. Its value during wait states has no effect.
- R8: A command accepted in the completing enable cycle starts its select phase on the next edge, with no idle cycle in between.
- R9: If no command is accepted in the completing cycle, all `psel` bits and `penable` are low on the next cycle.
- R10: An address with any bit above bit 13 set drives no select line. Such a command is accepted only while idle and gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0 on the next cycle.
- R11: `cmd_ready` is high when idle, or in an enable cycle with `pready` high and an in-map `cmd_addr`. It is low in the select cycle and during wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid is also high |
| cmd_addr | input | 16 | Command byte address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data (0 for writes and misses) |
| rsp_err | output | 1 | Peripheral error or decode miss |
| psel | output | 4 | One-hot peripheral selects |
| penable | output | 1 | Enable strobe of the access phase |
| paddr | output | 16 | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | 32 | Bus write data |
| pready | input | 1 | Peripheral ready |
| prdata | input | 32 | Peripheral read data |
| pslverr | input | 1 | Peripheral error |

## Verification
A wrong phase register shows up at the ports within one cycle. It appears as a select without a following enable, an enable that outlasts a high ready, or an enable with no select. A stale or corrupted command register shows up as a wrong select bit or a moving address during wait states. The bench samples the bus on every cycle of each transfer, so that kind of fault is caught in the cycle where it first appears. A response fault shows up one cycle after completion: a missing or doubled pulse, or an error flag taken from a wait state instead of the completing cycle.

// File: rtl/apbm_pkg.sv
package apbm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    localparam int DEF_ADDR_W    = 16;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_NUM_PERIPH = 4;
    localparam int DEF_SLOT_BITS = 12;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/apbm_decode.sv
module apbm_decode
    import apbm_pkg::*;
#(
    parameter int AW        = DEF_ADDR_W,
    parameter int NSLV      = DEF_NUM_PERIPH,
    parameter int SLOT_BITS = DEF_SLOT_BITS
) (
    input  logic [AW-1:SLOT_BITS] addr_hi,
    output logic                  hit,
    output logic [NSLV-1:0]       sel
);
    localparam int IDXW    = idx_width(NSLV);
    localparam int TOP_LSB = SLOT_BITS + IDXW;

    logic [IDXW-1:0] idx;
    logic            upper_ok;

    assign idx = addr_hi[SLOT_BITS +: IDXW];

    generate
        if (TOP_LSB < AW) begin : g_upper
            assign upper_ok = (addr_hi[AW-1:TOP_LSB] == '0);
        end else begin : g_noupper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign hit = upper_ok && (int'(idx) < NSLV);

    generate
        for (genvar i = 0; i < NSLV; i++) begin : g_sel
            assign sel[i] = hit && (idx == IDXW'(i));
        end
    endgenerate
endmodule

// File: rtl/apbm_seq.sv
module apbm_seq
    import apbm_pkg::*;
#(
    parameter int AW   = DEF_ADDR_W,
    parameter int DW   = DEF_DATA_W,
    parameter int NSLV = DEF_NUM_PERIPH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic            dec_hit,
    input  logic [NSLV-1:0] dec_sel,
    input  logic            pready,
    output logic            cmd_ready,
    output logic            done,
    output logic            miss,
    output phase_e          phase,
    output logic [NSLV-1:0] sel_q,
    output logic [AW-1:0]   addr_q,
    output logic            wr_q,
    output logic [DW-1:0]   wd_q
);
    logic accept;
    logic launch;

    assign done      = (phase == PH_ACCESS) && pready;
    assign cmd_ready = (phase == PH_IDLE) || (done && dec_hit);
    assign accept    = cmd_valid && cmd_ready;
    assign launch    = accept && dec_hit;
    assign miss      = accept && !dec_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            sel_q  <= '0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
        end else begin
            if (launch) begin
                sel_q  <= dec_sel;
                addr_q <= cmd_addr;
                wr_q   <= cmd_write;
                wd_q   <= cmd_wdata;
            end else if (done) begin
                sel_q <= '0;
            end
            case (phase)
                PH_IDLE:   if (launch) phase <= PH_SETUP;
                PH_SETUP:  phase <= PH_ACCESS;
                PH_ACCESS: if (pready) phase <= launch ? PH_SETUP : PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/apbm_rsp.sv
module apbm_rsp
    import apbm_pkg::*;
#(
    parameter int DW = DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic          miss,
    input  logic          wr_q,
    input  logic [DW-1:0] prdata,
    input  logic          pslverr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= done || miss;
            if (done) begin
                rsp_err   <= pslverr;
                rsp_rdata <= wr_q ? '0 : prdata;
            end else begin
                rsp_err   <= miss;
                rsp_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/apbm_requester.sv
module apbm_requester
    import apbm_pkg::*;
#(
    parameter int AW        = DEF_ADDR_W,
    parameter int DW        = DEF_DATA_W,
    parameter int NSLV      = DEF_NUM_PERIPH,
    parameter int SLOT_BITS = DEF_SLOT_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_write,
    input  logic [DW-1:0]   cmd_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_err,
    output logic [NSLV-1:0] psel,
    output logic            penable,
    output logic [AW-1:0]   paddr,
    output logic            pwrite,
    output logic [DW-1:0]   pwdata,
    input  logic            pready,
    input  logic [DW-1:0]   prdata,
    input  logic            pslverr
);
    logic            dec_hit;
    logic [NSLV-1:0] dec_sel;
    logic            done;
    logic            miss;
    phase_e          phase;

    apbm_decode #(.AW(AW), .NSLV(NSLV), .SLOT_BITS(SLOT_BITS)) u_dec (
        .addr_hi (cmd_addr[AW-1:SLOT_BITS]),
        .hit     (dec_hit),
        .sel     (dec_sel)
    );

    apbm_seq #(.AW(AW), .DW(DW), .NSLV(NSLV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_write (cmd_write),
        .cmd_wdata (cmd_wdata),
        .dec_hit   (dec_hit),
        .dec_sel   (dec_sel),
        .pready    (pready),
        .cmd_ready (cmd_ready),
        .done      (done),
        .miss      (miss),
        .phase     (phase),
        .sel_q     (psel),
        .addr_q    (paddr),
        .wr_q      (pwrite),
        .wd_q      (pwdata)
    );

    assign penable = (phase == PH_ACCESS);

    apbm_rsp #(.DW(DW)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .miss      (miss),
        .wr_q      (pwrite),
        .prdata    (prdata),
        .pslverr   (pslverr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );
endmodule

// File: rtl/apbm_checker.sv
module apbm_checker #(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int NSLV = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [NSLV-1:0] psel,
    input logic            penable,
    input logic            pready,
    input logic [AW-1:0]   paddr,
    input logic            pwrite,
    input logic [DW-1:0]   pwdata,
    input logic            rsp_valid
);
    a_r2_setup_then_access: assert property (@(posedge clk) disable iff (rst)
        (psel != '0 && !penable) |=> (penable && psel != '0));

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(psel));

    a_r3_enable_has_sel: assert property (@(posedge clk) disable iff (rst)
        penable |-> ($countones(psel) == 1));

    a_r4_bus_stable: assert property (@(posedge clk) disable iff (rst)
        (psel != '0 && !(penable && pready)) |=>
            ($stable(paddr) && $stable(pwrite) && $stable(pwdata) && $stable(psel)));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (penable && !pready) |=> penable);

    a_r6_response_follows: assert property (@(posedge clk) disable iff (rst)
        (penable && pready) |=> rsp_valid);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        (penable && pready && !(cmd_valid && cmd_ready)) |=> (psel == '0 && !penable));

    a_r11_no_take_in_setup: assert property (@(posedge clk) disable iff (rst)
        (psel != '0 && !penable) |-> !cmd_ready);
endmodule

bind apbm_requester apbm_checker #(.AW(AW), .DW(DW), .NSLV(NSLV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .psel      (psel),
    .penable   (penable),
    .pready    (pready),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_apbm_requester.sv
module tb_apbm_requester;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_write = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic [NS-1:0] psel;
    logic          penable;
    logic [AW-1:0] paddr;
    logic          pwrite;
    logic [DW-1:0] pwdata;
    logic          pready = 1'b0;
    logic [DW-1:0] prdata = '0;
    logic          pslverr = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    apbm_requester dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        wr;
        logic [31:0] wd;
        logic [3:0]  waits;
        logic        err;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0010, 1'b1, 32'hA5A5_0001, 4'd0, 1'b0, 32'h0},
        '{16'h1204, 1'b0, 32'h0,         4'd2, 1'b0, 32'h1234_5678},
        '{16'h2FFC, 1'b1, 32'hDEAD_BEEF, 4'd1, 1'b1, 32'h0},
        '{16'h3000, 1'b0, 32'h0,         4'd3, 1'b1, 32'hCAFE_F00D},
        '{16'h3FFF, 1'b0, 32'h0,         4'd0, 1'b0, 32'h0BAD_F00D},
        '{16'h0000, 1'b1, 32'hFFFF_FFFF, 4'd2, 1'b0, 32'h0}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] sel_of(input logic [AW-1:0] a);
        return NS'(1) << a[13:12];
    endfunction

    // Offer a command at a negedge; the caller is at a negedge in IDLE.
    task automatic run_txn(input vec_t v);
        logic [NS-1:0] es;
        es = sel_of(v.addr);
        cmd_valid = 1'b1; cmd_addr = v.addr; cmd_write = v.wr; cmd_wdata = v.wd;
        pready = 1'b0;
        #1 chk("R11", "ready idle", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_addr = 16'hFFFF;
        chk("R2", "setup sel", psel, es);
        chk("R2", "setup enable", penable, 0);
        chk("R4", "setup addr", paddr, v.addr);
        chk("R4", "setup dir", pwrite, v.wr);
        chk("R11", "ready in setup", cmd_ready, 0);
        @(negedge clk);
        chk("R2", "access enable", penable, 1);
        for (int w = 0; w < int'(v.waits); w++) begin
            pready = 1'b0; pslverr = ~v.err; prdata = ~v.rd;
            #1 chk("R11", "ready in wait", cmd_ready, 0);
            @(negedge clk);
            chk("R5", "wait enable", penable, 1);
            chk("R4", "wait sel", psel, es);
            chk("R4", "wait addr", paddr, v.addr);
            chk("R4", "wait wdata", pwdata, v.wr ? v.wd : pwdata);
        end
        pready = 1'b1; pslverr = v.err; prdata = v.rd;
        @(negedge clk);
        pready = 1'b0; pslverr = ~v.err; prdata = 32'h5555_AAAA;
        chk("R6", "rsp valid", rsp_valid, 1);
        chk("R6", "rsp data", rsp_rdata, v.wr ? 32'h0 : v.rd);
        chk("R7", "rsp err", rsp_err, v.err);
        chk("R9", "idle sel", psel, 0);
        chk("R9", "idle enable", penable, 0);
        @(negedge clk);
        chk("R6", "single pulse", rsp_valid, 0);
        pslverr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet under reset, even with a command offered
        cmd_valid = 1'b1; cmd_addr = 16'h1000; pready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "reset sel", psel, 0);
        chk("R1", "reset enable", penable, 0);
        chk("R1", "reset rsp", rsp_valid, 0);
        cmd_valid = 1'b0; pready = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle after reset", cmd_ready, 1);

        // table walk
        foreach (VECS[i]) run_txn(VECS[i]);

        // R8: back-to-back, no idle cycle
        cmd_valid = 1'b1; cmd_addr = 16'h1100; cmd_write = 1'b0;
        @(negedge clk);
        cmd_addr = 16'h2200; cmd_write = 1'b1; cmd_wdata = 32'h0F0F_0F0F;
        @(negedge clk);
        pready = 1'b1; prdata = 32'h7777_0001;
        #1 chk("R11", "ready at completion", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0; pready = 1'b0;
        chk("R8", "next setup sel", psel, 4'b0100);
        chk("R8", "next setup enable", penable, 0);
        chk("R8", "next addr", paddr, 16'h2200);
        chk("R6", "first rsp data", rsp_rdata, 32'h7777_0001);
        @(negedge clk);
        chk("R8", "next access", penable, 1);
        // R10/R11: miss offered at completion is held off
        cmd_valid = 1'b1; cmd_addr = 16'h4000; pready = 1'b1;
        #1 chk("R11", "miss held at completion", cmd_ready, 0);
        @(negedge clk);
        pready = 1'b0;
        chk("R10", "write done sel", psel, 0);
        chk("R6", "write rsp", rsp_valid, 1);
        chk("R6", "write rdata zero", rsp_rdata, 0);
        // now idle: miss is accepted
        #1 chk("R10", "miss ready idle", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10", "miss no sel", psel, 0);
        chk("R10", "miss no enable", penable, 0);
        chk("R10", "miss rsp", rsp_valid, 1);
        chk("R10", "miss err", rsp_err, 1);
        chk("R10", "miss data", rsp_rdata, 0);
        @(negedge clk);
        chk("R10", "miss single", rsp_valid, 0);

        // R1: reset in the middle of an access
        cmd_valid = 1'b1; cmd_addr = 16'h3010; cmd_write = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R2", "access before reset", penable, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid reset sel", psel, 0);
        chk("R1", "mid reset enable", penable, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "no rsp after reset", rsp_valid, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule